// File: doc/BRIEF.md
# Two-Stage Parallel-to-Serial Converter

This block turns parallel words into a serial bit stream. It has two register stages. A holding register keeps the last word offered on the parallel input and changes only when the capture strobe is high. A shift chain of the same width can take a word from the holding register, be cleared to zero, or move one place per shift strobe. When it moves, a new serial bit enters at the bottom. Only the top stage of the chain reaches the serial output.

Everything runs on one clock. The capture and shift strobes are single-cycle enables. The load and clear controls are active-low levels that are sampled on every edge. A decoder reduces those levels and the shift strobe to one named chain operation per cycle: HOLD, CLEAR, LOAD or SHIFT. When both controls are low, CLEAR wins. When a capture and a load happen in the same cycle, the incoming word goes straight to the chain; it does not wait for a second load.

Top module: `psr_top`

## Requirements
- R1: When `cap_stb` is 1, the holding register takes `par_in` at that edge, whatever `ld_n`, `clr_n` and `shf_stb` are.
- R2: When `cap_stb` is 0, the holding register keeps its word. This includes cycles with clear asserted.
- R3: With `clr_n`=1 and `ld_n`=0 (operation LOAD), the chain takes the holding register's word. Bit i of the word goes to chain stage i.
- R4: With LOAD and `cap_stb`=1 in the same cycle, the chain takes the `par_in` word of that cycle.
- R5: With `clr_n`=0 (operation CLEAR), the chain becomes all zeros and the holding register is untouched.
- R6: With `clr_n`=1, `ld_n`=1 and `shf_stb`=1 (operation SHIFT), stage i+1 takes stage i and stage 0 takes `ser_in`. `ser_out` is always the top stage, index WIDTH-1.
- R7: `shf_stb` has no effect while `ld_n`=0.
- R8: With `clr_n`=0 and `ld_n`=0 together, the chain becomes zero. It stays zero after both controls are released until a later LOAD or SHIFT.
- R9: With `clr_n`=1, `ld_n`=1 and `shf_stb`=0 (operation HOLD), the chain keeps its value.
- R10: `rst_n`=0 at an edge zeros both the holding register and the chain.
- R11: A LOAD, CLEAR or SHIFT sampled at edge N appears on `ser_out` right after edge N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_stb | input | 1 | Capture strobe for the holding register |
| par_in | input | WIDTH | Parallel word |
| ld_n | input | 1 | Load the chain from the holding register, active low |
| clr_n | input | 1 | Clear the chain, active low |
| shf_stb | input | 1 | Shift strobe for the chain |
| ser_in | input | 1 | Bit entering chain stage 0 on a shift |
| ser_out | output | 1 | Top stage of the chain |

## Verification
The assertions check on every cycle how each chain operation relates to the next chain value: the step of a shift, the stability of a hold, the zero after a clear, the loaded word, and the pass-through of a word captured in the same cycle. They also check that the holding register captures on a strobe and stays still otherwise. Some behaviour only the bench scenarios can show. These are that clear leaves the stored word intact, which is seen by loading and shifting it out later. Another is that a clear held with a load keeps the chain at zero across the idle cycles after both are released. The last is that reset wipes the stored word as well as the chain.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_SHIFT = 2'd3
    } chain_op_e;
endpackage

// File: rtl/psr_hold_reg.sv
module psr_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_stb,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] fwd_word
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored <= '0;
        else if (cap_stb)
            stored <= par_in;
    end

    // a word captured this cycle bypasses straight to the chain
    always_comb begin
        fwd_word = cap_stb ? par_in : stored;
    end

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> stored == $past(par_in)); // R1
    AST_KEEP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_stb |=> $stable(stored)); // R2
endmodule

// File: rtl/psr_op_decode.sv
module psr_op_decode
    import psr_pkg::*;
(
    input  logic      ld_n,
    input  logic      clr_n,
    input  logic      shf_stb,
    output chain_op_e op
);
    always_comb begin
        unique case ({clr_n, ld_n})
            2'b00:   op = OP_CLEAR;  // clear wins over load
            2'b01:   op = OP_CLEAR;
            2'b10:   op = OP_LOAD;   // shift strobe ignored
            default: op = shf_stb ? OP_SHIFT : OP_HOLD;
        endcase
    end
endmodule

// File: rtl/psr_shift_chain.sv
module psr_shift_chain
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chain_op_e        op,
    input  logic [WIDTH-1:0] fwd_word,
    input  logic             ser_in,
    output logic [WIDTH-1:0] chain
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            unique case (op)
                OP_HOLD:  chain <= chain;
                OP_CLEAR: chain <= '0;
                OP_LOAD:  chain <= fwd_word;
                OP_SHIFT: chain <= {chain[WIDTH-2:0], ser_in};
                default:  chain <= chain;
            endcase
        end
    end

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SHIFT |=> chain == {$past(chain[WIDTH-2:0]), $past(ser_in)}); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_HOLD |=> $stable(chain)); // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CLEAR |=> chain == '0); // R5
    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOAD |=> chain == $past(fwd_word)); // R3
endmodule

// File: rtl/psr_top.sv
module psr_top
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_stb,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ld_n,
    input  logic             clr_n,
    input  logic             shf_stb,
    input  logic             ser_in,
    output logic             ser_out
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] stored;
    logic [WIDTH-1:0] fwd_word;
    logic [WIDTH-1:0] chain;
    chain_op_e        op;

    psr_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .par_in(par_in),
        .stored(stored), .fwd_word(fwd_word)
    );

    psr_op_decode u_dec (
        .ld_n(ld_n), .clr_n(clr_n), .shf_stb(shf_stb), .op(op)
    );

    psr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk(clk), .rst_n(rst_n), .op(op), .fwd_word(fwd_word),
        .ser_in(ser_in), .chain(chain)
    );

    assign ser_out = chain[TOP];

    AST_THRU_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n && cap_stb) |=> ser_out == $past(par_in[TOP])); // R4
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !ld_n) |=> ser_out == 1'b0); // R8
    AST_LD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ld_n && shf_stb && !cap_stb) |=> ser_out == $past(stored[TOP])); // R7
endmodule

// File: tb/psr_top_test.sv
module psr_top_test;
    localparam int W   = 8;
    localparam int PER = 10;

    logic         clk = 1'b0;
    logic         rst_n, cap_stb, ld_n, clr_n, shf_stb, ser_in;
    logic [W-1:0] par_in;
    logic         ser_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_store = '0;
    logic [W-1:0] m_chain = '0;

    logic  exp_q[$];
    string tag_q[$];

    psr_top #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .par_in(par_in),
        .ld_n(ld_n), .clr_n(clr_n), .shf_stb(shf_stb), .ser_in(ser_in),
        .ser_out(ser_out)
    );

    always #(PER/2) clk = ~clk;

    // driver: apply one cycle of stimulus, advance the model, queue the expectation
    task automatic step(input logic r, input logic cs, input logic [W-1:0] pw,
                        input logic l, input logic c, input logic ss,
                        input logic si, input string tag);
        logic [W-1:0] src;
        rst_n = r; cap_stb = cs; par_in = pw; ld_n = l; clr_n = c;
        shf_stb = ss; ser_in = si;
        src = cs ? pw : m_store;
        if (!r) begin
            m_store = '0; m_chain = '0;
        end else begin
            if (!c)            m_chain = '0;
            else if (!l)       m_chain = src;
            else if (ss)       m_chain = {m_chain[W-2:0], si};
            if (cs)            m_store = pw;
        end
        exp_q.push_back(m_chain[W-1]);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, '0, 1, 1, 0, 0, tag);
    endtask

    task automatic shift_out(input int n, input logic [W-1:0] bits, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, '0, 1, 1, 1, bits[i], tag);
    endtask

    // monitor: compare the output a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(PER/4);
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (ser_out !== e) begin
                    bad++;
                    $display("FAIL %s: ser_out=%0b expected=%0b at %0t", t, ser_out, e, $time);
                end
            end
        end
    end

    initial begin
        #(PER*200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step(0, 0, '0, 1, 1, 0, 0, "R10");
        step(0, 0, '0, 1, 1, 0, 0, "R10");
        // R1 capture, R3 load, R11 next-cycle visibility, R6 shift out
        step(1, 1, 8'hA5, 1, 1, 0, 0, "R1");
        step(1, 0, '0, 0, 1, 0, 0, "R11");
        shift_out(W, 8'b0110_1001, "R6");
        // R5: clear while capturing, then the stored word survives
        step(1, 0, '0, 0, 1, 0, 0, "R3");
        step(1, 1, 8'h3C, 1, 0, 0, 0, "R5");
        idle(2, "R9");
        step(1, 0, '0, 0, 1, 0, 0, "R2");
        shift_out(W, 8'hFF, "R2");
        // R4: capture and load in the same cycle
        step(1, 1, 8'h81, 0, 1, 0, 0, "R4");
        shift_out(W, 8'h00, "R4");
        // R7: shift strobe ignored while load held
        step(1, 1, 8'hC3, 1, 1, 0, 0, "R1");
        for (int i = 0; i < 4; i++) step(1, 0, '0, 0, 1, 1, 1, "R7");
        shift_out(W, 8'h55, "R7");
        // R8: clear with load, then release and idle
        step(1, 1, 8'hFF, 1, 1, 0, 0, "R1");
        step(1, 0, '0, 0, 1, 0, 0, "R3");
        step(1, 0, '0, 0, 0, 1, 1, "R8");
        step(1, 0, '0, 0, 0, 0, 0, "R8");
        idle(3, "R8");
        shift_out(W, 8'hF0, "R8");
        // R9: hold with nothing active
        idle(4, "R9");
        // R10: mid-run reset wipes the stored word
        step(1, 1, 8'hFF, 0, 1, 0, 0, "R4");
        step(0, 0, '0, 1, 1, 0, 0, "R10");
        step(1, 0, '0, 0, 1, 0, 0, "R10");
        shift_out(W, 8'h00, "R10");
        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] rv;
            rv = 8'($urandom);
            step(1, rv[0], 8'($urandom), (rv[3:1] != 3'b000), (rv[6:4] != 3'b000),
                 rv[7], 1'($urandom), "R11");
        end
        idle(2, "R9");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule